// File: doc/BRIEF.md
# Audio Clock Ratio Auto-Detector

This block sits in front of a slave-mode audio converter core and works out how the incoming audio clocks relate to each other. It watches a master clock, a frame (left/right) clock and a bit clock. It decides whether the stream runs at single or double speed, which master-clock-per-frame ratio is in use, and whether the core must divide the master clock by two to reach its fixed internal rate. It also reports the bit-clock-per-frame ratio.

All measurement runs on a free-running reference clock. The three audio clocks are synchronised into that domain and their rising edges are counted. Two measurements are taken on every frame. The first is the number of master-clock rising edges between consecutive frame-clock rising edges. The second is the frame period in reference cycles. The period picks the speed mode, which is what separates the 256x and 384x ratios that are legal in both modes. The edge count is then decoded against the legal ratios of that mode. A classification is reported only after two identical consecutive frames. If the master clock stops, the block drops into power-down. The first new master-clock edge brings it out again, and detection restarts from scratch.

Top module: `clk_ratio_detect`

## Requirements
- R1: After reset every output is 0: single speed, ratio code 0, divide select low, not locked, not powered down, bit-clock code 0, no rate error.
- R2: `locked` rises only after two consecutive complete frames give the same legal classification. After only one such frame it stays low.
- R3: A frame period within [DS_MIN, DS_MAX] reference cycles reports double speed (`speedDouble`=1). A period within [SS_MIN, SS_MAX] reports single speed (`speedDouble`=0).
- R4: The ratio code is 1=128x, 2=192x, 3=256x, 4=384x, 5=512x, 6=768x, and 0 when unlocked. Legal codes are 1 to 4 in double speed and 3 to 6 in single speed.
- R5: A 256x or 384x edge count is classified as double speed or single speed by the frame period alone, with the matching divide select.
- R6: `div2Sel` is 1 for 512x and 768x in single speed and for 256x and 384x in double speed, and 0 otherwise.
- R7: The bit-clock code is 1 for 64 bit-clock edges per frame and 2 for 48. A count of 48 is accepted only with 192x, 384x or 768x; any other pairing never locks.
- R8: A frame period outside both windows sets `rateErr` at the end of that frame and keeps `locked` low.
- R9: An edge count that is not legal for the speed the period selects never locks, even when it is legal in the other speed, and does not set `rateErr`.
- R10: A frame whose classification differs from the previous one clears `locked`. While unlocked, the ratio code, bit-clock code, speed and divide select read 0.
- R11: If the master clock shows no edge for IDLE_LIMIT (1024) reference cycles, `powerDown` goes high and `locked` goes low. It does not assert earlier.
- R12: The first master-clock edge during power-down clears `powerDown` and restarts detection. A valid stream then locks again after two matching frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock; all logic runs on it |
| rstN | input | 1 | Synchronous active-low reset |
| mclkIn | input | 1 | Incoming master clock (asynchronous) |
| lrckIn | input | 1 | Incoming frame clock (asynchronous) |
| sclkIn | input | 1 | Incoming bit clock (asynchronous) |
| speedDouble | output | 1 | 1 = double speed, 0 = single speed |
| ratioCode | output | 3 | Master-clock-per-frame ratio code (R4) |
| div2Sel | output | 1 | Master-clock divide-by-two select |
| locked | output | 1 | Classification confirmed on two frames |
| powerDown | output | 1 | Master clock found static |
| sclkRatio | output | 2 | Bit-clock-per-frame code (R7) |
| rateErr | output | 1 | Last frame period fell outside both windows |

## Verification
The properties assume two things about the audio clocks. Each level of every audio clock is held for at least one reference cycle. The frame-period windows are ordered with DS_MAX below SS_MIN, so a period selects at most one speed. The static-clock property also relies on the power-down counter being reset only by master-clock edges. The stimulus generator meets these assumptions by construction. It derives all three audio clocks from a cycle counter on the reference clock, with the master-clock half-period an integer number of reference cycles. It places frame-clock and bit-clock rising edges in cycles where the master clock is low, so frame counts come out exact.

// File: rtl/crd_pkg.sv
package crd_pkg;

  // Strobes from control to the measurement datapath.
  typedef struct packed {
    logic restart;
  } ctrlStrobe_t;

  // Events from the datapath to control.
  typedef struct packed {
    logic frameDone;
    logic mclkEdge;
    logic idleHit;
  } measEvt_t;

  typedef enum logic [2:0] {
    RC_NONE = 3'd0,
    RC_128  = 3'd1,
    RC_192  = 3'd2,
    RC_256  = 3'd3,
    RC_384  = 3'd4,
    RC_512  = 3'd5,
    RC_768  = 3'd6
  } ratioCode_t;

endpackage

// File: rtl/crd_meas.sv
module crd_meas
  import crd_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SCW         = 7,
  parameter int PER_W       = 12,
  parameter int IDLE_LIMIT  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mclkIn,
  input  logic             lrckIn,
  input  logic             sclkIn,
  input  ctrlStrobe_t      strobe,
  output measEvt_t         evt,
  output logic [CNT_W-1:0] mclkCount,
  output logic [SCW-1:0]   sclkCount,
  output logic [PER_W-1:0] frameLen
);
  localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [SCW-1:0]   SC_MAX  = '1;
  localparam logic [PER_W-1:0] PER_MAX = '1;

  // Synchroniser chain, one bit per audio clock: {sclk, lrck, mclk}
  logic [2:0] syncQ [SYNC_STAGES];
  logic [2:0] prevLvl;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= {sclkIn, lrckIn, mclkIn};
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= syncQ[SYNC_STAGES-1];
  end

  logic [2:0] lvl;
  logic mclkRise, lrckRise, sclkRise, mclkAny;
  assign lvl      = syncQ[SYNC_STAGES-1];
  assign mclkRise = lvl[0] & ~prevLvl[0];
  assign mclkAny  = lvl[0] ^ prevLvl[0];
  assign lrckRise = lvl[1] & ~prevLvl[1];
  assign sclkRise = lvl[2] & ~prevLvl[2];

  // Static master-clock watchdog
  logic [IDLE_W-1:0] idleCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                                   idleCnt <= '0;
    else if (mclkAny)                            idleCnt <= '0;
    else if (idleCnt != IDLE_W'(IDLE_LIMIT))     idleCnt <= idleCnt + 1'b1;
  end

  // Per-frame counters with saturation
  logic [CNT_W-1:0] mcCnt, mcNext;
  logic [SCW-1:0]   scCnt, scNext;
  logic [PER_W-1:0] pCnt, pNext;
  logic             armed, frameDoneQ;

  assign mcNext = (mcCnt == CNT_MAX) ? mcCnt : mcCnt + CNT_W'(mclkRise);
  assign scNext = (scCnt == SC_MAX)  ? scCnt : scCnt + SCW'(sclkRise);
  assign pNext  = (pCnt == PER_MAX)  ? pCnt  : pCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) begin
      mcCnt <= '0; scCnt <= '0; pCnt <= '0;
      mclkCount <= '0; sclkCount <= '0; frameLen <= '0;
      armed <= 1'b0; frameDoneQ <= 1'b0;
    end else begin
      frameDoneQ <= lrckRise & armed;
      if (lrckRise) begin
        armed     <= 1'b1;
        mclkCount <= mcNext;
        sclkCount <= scNext;
        frameLen  <= pNext;
        mcCnt <= '0; scCnt <= '0; pCnt <= '0;
      end else begin
        mcCnt <= mcNext; scCnt <= scNext; pCnt <= pNext;
      end
    end
  end

  assign evt.frameDone = frameDoneQ;
  assign evt.mclkEdge  = mclkAny;
  assign evt.idleHit   = (idleCnt == IDLE_W'(IDLE_LIMIT));

endmodule

// File: rtl/crd_ctrl.sv
module crd_ctrl
  import crd_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int SCW    = 7,
  parameter int PER_W  = 12,
  parameter int DS_MIN = 240,
  parameter int DS_MAX = 800,
  parameter int SS_MIN = 1000,
  parameter int SS_MAX = 3200
) (
  input  logic             clk,
  input  logic             rstN,
  input  measEvt_t         evt,
  input  logic [CNT_W-1:0] mclkCount,
  input  logic [SCW-1:0]   sclkCount,
  input  logic [PER_W-1:0] frameLen,
  output ctrlStrobe_t      strobe,
  output logic             speedDouble,
  output logic [2:0]       ratioCode,
  output logic             div2Sel,
  output logic             locked,
  output logic             powerDown,
  output logic [1:0]       sclkRatio,
  output logic             rateErr
);
  localparam logic [PER_W-1:0] DS_LO = PER_W'(DS_MIN);
  localparam logic [PER_W-1:0] DS_HI = PER_W'(DS_MAX);
  localparam logic [PER_W-1:0] SS_LO = PER_W'(SS_MIN);
  localparam logic [PER_W-1:0] SS_HI = PER_W'(SS_MAX);

  function automatic ratioCode_t decodeCount(input logic [CNT_W-1:0] c);
    case (c)
      CNT_W'(128): return RC_128;
      CNT_W'(192): return RC_192;
      CNT_W'(256): return RC_256;
      CNT_W'(384): return RC_384;
      CNT_W'(512): return RC_512;
      CNT_W'(768): return RC_768;
      default:     return RC_NONE;
    endcase
  endfunction

  // Per-frame classification
  logic       inDs, inSs, legalRc, sc48Ok, newValid, newDiv2, match;
  ratioCode_t rc;
  logic [1:0] sc;

  always_comb begin
    inDs = (frameLen >= DS_LO) && (frameLen <= DS_HI);
    inSs = (frameLen >= SS_LO) && (frameLen <= SS_HI);
    rc   = decodeCount(mclkCount);
    if (inDs) legalRc = (rc == RC_128) || (rc == RC_192) || (rc == RC_256) || (rc == RC_384);
    else      legalRc = (rc == RC_256) || (rc == RC_384) || (rc == RC_512) || (rc == RC_768);
    if (sclkCount == SCW'(64))      sc = 2'd1;
    else if (sclkCount == SCW'(48)) sc = 2'd2;
    else                            sc = 2'd0;
    sc48Ok   = (rc == RC_192) || (rc == RC_384) || (rc == RC_768);
    newValid = (inDs || inSs) && legalRc && (sc != 2'd0) && ((sc != 2'd2) || sc48Ok);
    newDiv2  = inDs ? ((rc == RC_256) || (rc == RC_384))
                    : ((rc == RC_512) || (rc == RC_768));
  end

  // Candidate from the previous frame
  logic             candValid, candSpeed;
  logic [CNT_W-1:0] candCount;
  logic [1:0]       candSclk;

  assign match = newValid && candValid && (candCount == mclkCount)
              && (candSpeed == inDs) && (candSclk == sc);

  // Power-down tracking
  logic pdReg;
  always_ff @(posedge clk) begin
    if (!rstN)                     pdReg <= 1'b0;
    else if (pdReg && evt.mclkEdge) pdReg <= 1'b0;
    else if (evt.idleHit)          pdReg <= 1'b1;
  end

  assign strobe.restart = pdReg | evt.idleHit;

  ratioCode_t outCode;
  logic       outSpeed, outDiv2, lockReg, errReg;
  logic [1:0] outSclk;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.restart) begin
      candValid <= 1'b0; candSpeed <= 1'b0; candCount <= '0; candSclk <= '0;
      lockReg <= 1'b0; errReg <= 1'b0;
      outCode <= RC_NONE; outSpeed <= 1'b0; outDiv2 <= 1'b0; outSclk <= '0;
    end else if (evt.frameDone) begin
      candValid <= newValid;
      candSpeed <= inDs;
      candCount <= mclkCount;
      candSclk  <= sc;
      errReg    <= !(inDs || inSs);
      lockReg   <= match;
      if (match) begin
        outCode <= rc; outSpeed <= inDs; outDiv2 <= newDiv2; outSclk <= sc;
      end else begin
        outCode <= RC_NONE; outSpeed <= 1'b0; outDiv2 <= 1'b0; outSclk <= '0;
      end
    end
  end

  assign speedDouble = outSpeed;
  assign ratioCode   = outCode;
  assign div2Sel     = outDiv2;
  assign locked      = lockReg;
  assign powerDown   = pdReg;
  assign sclkRatio   = outSclk;
  assign rateErr     = errReg;

endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
  import crd_pkg::*;
#(
  parameter int DS_MIN      = 240,
  parameter int DS_MAX      = 800,
  parameter int SS_MIN      = 1000,
  parameter int SS_MAX      = 3200,
  parameter int IDLE_LIMIT  = 1024,
  parameter int MAX_RATIO   = 768,
  parameter int MAX_SCLK    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       mclkIn,
  input  logic       lrckIn,
  input  logic       sclkIn,
  output logic       speedDouble,
  output logic [2:0] ratioCode,
  output logic       div2Sel,
  output logic       locked,
  output logic       powerDown,
  output logic [1:0] sclkRatio,
  output logic       rateErr
);
  localparam int CNT_W = $clog2(MAX_RATIO + 2);
  localparam int SCW   = $clog2(MAX_SCLK + 2);
  localparam int PER_W = $clog2(SS_MAX + 2);

  ctrlStrobe_t      strobe;
  measEvt_t         evt;
  logic [CNT_W-1:0] mclkCount;
  logic [SCW-1:0]   sclkCount;
  logic [PER_W-1:0] frameLen;

  crd_meas #(
    .CNT_W(CNT_W), .SCW(SCW), .PER_W(PER_W),
    .IDLE_LIMIT(IDLE_LIMIT), .SYNC_STAGES(SYNC_STAGES)
  ) meas_i (
    .clk(refClk), .rstN(rstN), .mclkIn(mclkIn), .lrckIn(lrckIn), .sclkIn(sclkIn),
    .strobe(strobe), .evt(evt), .mclkCount(mclkCount), .sclkCount(sclkCount),
    .frameLen(frameLen)
  );

  crd_ctrl #(
    .CNT_W(CNT_W), .SCW(SCW), .PER_W(PER_W),
    .DS_MIN(DS_MIN), .DS_MAX(DS_MAX), .SS_MIN(SS_MIN), .SS_MAX(SS_MAX)
  ) ctrl_i (
    .clk(refClk), .rstN(rstN), .evt(evt), .mclkCount(mclkCount),
    .sclkCount(sclkCount), .frameLen(frameLen), .strobe(strobe),
    .speedDouble(speedDouble), .ratioCode(ratioCode), .div2Sel(div2Sel),
    .locked(locked), .powerDown(powerDown), .sclkRatio(sclkRatio), .rateErr(rateErr)
  );

endmodule

// File: rtl/crd_checker.sv
module crd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       mclkIn,
  input logic       speedDouble,
  input logic [2:0] ratioCode,
  input logic       div2Sel,
  input logic       locked,
  input logic       powerDown,
  input logic [1:0] sclkRatio,
  input logic       rateErr
);

  AST_PD_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> !locked); // R11

  AST_PD_STATIC_CLK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerDown) |-> $stable(mclkIn)); // R11

  AST_ERR_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    rateErr |-> !locked); // R8

  AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (speedDouble ? (ratioCode >= 3'd1 && ratioCode <= 3'd4)
                            : (ratioCode >= 3'd3 && ratioCode <= 3'd6))); // R4

  AST_DIV2_RULE: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (div2Sel == (speedDouble ? (ratioCode == 3'd3 || ratioCode == 3'd4)
                                        : (ratioCode == 3'd5 || ratioCode == 3'd6)))); // R6

  AST_SCLK48_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (locked && sclkRatio == 2'd2) |-> (ratioCode == 3'd2 || ratioCode == 3'd4 || ratioCode == 3'd6)); // R7

  AST_UNLOCK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> (ratioCode == 3'd0 && sclkRatio == 2'd0 && !div2Sel && !speedDouble)); // R10

endmodule

bind clk_ratio_detect crd_checker chk_i (
  .clk(refClk), .rstN(rstN), .mclkIn(mclkIn), .speedDouble(speedDouble),
  .ratioCode(ratioCode), .div2Sel(div2Sel), .locked(locked), .powerDown(powerDown),
  .sclkRatio(sclkRatio), .rateErr(rateErr)
);

// File: tb/clk_ratio_detect_tb_top.sv
`timescale 1ns/1ps
module clk_ratio_detect_tb_top;

  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic mclkIn = 1'b0, lrckIn = 1'b0, sclkIn = 1'b0;
  logic speedDouble, div2Sel, locked, powerDown, rateErr;
  logic [2:0] ratioCode;
  logic [1:0] sclkRatio;

  always #10 refClk = ~refClk; // 50 MHz

  clk_ratio_detect dut_i (
    .refClk(refClk), .rstN(rstN), .mclkIn(mclkIn), .lrckIn(lrckIn), .sclkIn(sclkIn),
    .speedDouble(speedDouble), .ratioCode(ratioCode), .div2Sel(div2Sel),
    .locked(locked), .powerDown(powerDown), .sclkRatio(sclkRatio), .rateErr(rateErr)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Clock generator: all audio clocks derived from a reference-cycle counter.
  int curRatio = 128, curHalf = 1, curSclk = 64;
  int loadSeq = 0, seenSeq = 0, t = 0;
  bit stopped = 1'b1;

  always @(negedge refClk) begin
    int frameRef;
    if (stopped) begin
      mclkIn = 1'b0; lrckIn = 1'b0; sclkIn = 1'b0; t = 0;
    end else begin
      if (seenSeq != loadSeq) begin t = 0; seenSeq = loadSeq; end
      frameRef = curRatio * 2 * curHalf;
      mclkIn = (((t / curHalf) % 2) == 1) ? 1'b1 : 1'b0;
      lrckIn = (t >= frameRef / 2) ? 1'b1 : 1'b0;
      sclkIn = ((((t * 2 * curSclk) / frameRef) % 2) == 1) ? 1'b1 : 1'b0;
      t = (t + 1) % frameRef;
    end
  end

  typedef struct packed {
    logic [10:0] ratio;
    logic [2:0]  half;
    logic [6:0]  nSclk;
    logic        lock;
    logic        spd;
    logic [2:0]  code;
    logic        div2;
    logic [1:0]  sc;
    logic        err;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{11'd128, 3'd1, 7'd64, 1'b1, 1'b1, 3'd1, 1'b0, 2'd1, 1'b0},
    '{11'd192, 3'd1, 7'd48, 1'b1, 1'b1, 3'd2, 1'b0, 2'd2, 1'b0},
    '{11'd256, 3'd1, 7'd64, 1'b1, 1'b1, 3'd3, 1'b1, 2'd1, 1'b0},
    '{11'd384, 3'd1, 7'd48, 1'b1, 1'b1, 3'd4, 1'b1, 2'd2, 1'b0},
    '{11'd256, 3'd2, 7'd64, 1'b1, 1'b0, 3'd3, 1'b0, 2'd1, 1'b0},
    '{11'd384, 3'd2, 7'd48, 1'b1, 1'b0, 3'd4, 1'b0, 2'd2, 1'b0},
    '{11'd512, 3'd2, 7'd64, 1'b1, 1'b0, 3'd5, 1'b1, 2'd1, 1'b0},
    '{11'd768, 3'd2, 7'd48, 1'b1, 1'b0, 3'd6, 1'b1, 2'd2, 1'b0},
    '{11'd300, 3'd2, 7'd64, 1'b0, 1'b0, 3'd0, 1'b0, 2'd0, 1'b0},
    '{11'd256, 3'd1, 7'd48, 1'b0, 1'b0, 3'd0, 1'b0, 2'd0, 1'b0},
    '{11'd448, 3'd1, 7'd64, 1'b0, 1'b0, 3'd0, 1'b0, 2'd0, 1'b1},
    '{11'd64,  3'd1, 7'd64, 1'b0, 1'b0, 3'd0, 1'b0, 2'd0, 1'b1},
    '{11'd768, 3'd3, 7'd64, 1'b0, 1'b0, 3'd0, 1'b0, 2'd0, 1'b1},
    '{11'd128, 3'd4, 7'd64, 1'b0, 1'b0, 3'd0, 1'b0, 2'd0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge refClk);
  endtask

  task automatic loadClk(input int ratio, input int half, input int nS);
    @(posedge refClk);
    curRatio = ratio; curHalf = half; curSclk = nS;
    loadSeq++;
    stopped = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge refClk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitCyc(5);
    @(negedge refClk);
    rstN = 1'b1;
    waitCyc(3);
    @(negedge refClk);
    // R1: reset state
    chk("R1 locked", int'(locked), 0);
    chk("R1 powerDown", int'(powerDown), 0);
    chk("R1 ratioCode", int'(ratioCode), 0);
    chk("R1 speed/div2/sclk/err", int'({speedDouble, div2Sel, sclkRatio, rateErr}), 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int fr;
      v = VECS[i];
      fr = int'(v.ratio) * 2 * int'(v.half);
      loadClk(int'(v.ratio), int'(v.half), int'(v.nSclk));
      waitCyc(fr);
      @(negedge refClk);
      chk("R10 unlock after changed frame", int'(locked), 0);
      chk("R10 ratio cleared while unlocked", int'(ratioCode), 0);
      waitCyc(fr);
      @(negedge refClk);
      chk("R2 no lock after one frame", int'(locked), 0);
      waitCyc(2 * fr);
      @(negedge refClk);
      chk(v.lock ? "R2 locked" : (v.err ? "R8 no lock" : "R9 no lock"), int'(locked), int'(v.lock));
      chk((v.code == 3'd3 || v.code == 3'd4) ? "R5 speed by rate" : "R3 speed", int'(speedDouble), int'(v.spd));
      chk("R4 ratio code", int'(ratioCode), int'(v.code));
      chk("R6 div2", int'(div2Sel), int'(v.div2));
      chk("R7 sclk code", int'(sclkRatio), int'(v.sc));
      chk("R8 rate error", int'(rateErr), int'(v.err));
    end

    // Static master clock: lock first, then stop all clocks.
    loadClk(256, 1, 64);
    waitCyc(4 * 512);
    @(negedge refClk);
    chk("R11 locked before stop", int'(locked), 1);
    @(posedge refClk);
    stopped = 1'b1;
    waitCyc(900);
    @(negedge refClk);
    chk("R11 no early power-down", int'(powerDown), 0);
    waitCyc(200);
    @(negedge refClk);
    chk("R11 power-down", int'(powerDown), 1);
    chk("R11 unlocked in power-down", int'(locked), 0);

    // Restart: first edge wakes, then relock.
    loadClk(192, 1, 48);
    waitCyc(20);
    @(negedge refClk);
    chk("R12 wake on edge", int'(powerDown), 0);
    chk("R12 unlocked after wake", int'(locked), 0);
    waitCyc(4 * 384);
    @(negedge refClk);
    chk("R12 relock", int'(locked), 1);
    chk("R12 relock ratio", int'(ratioCode), 2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule